// File: doc/BRIEF.md
# Serial Conversion Result Port

This block sends a 16-bit converter result out on a single data line, most significant bit first, from an internal shift register. It runs in one of two roles. As clock master it makes its own serial clock and a frame-sync output. As clock slave it follows an external serial clock, and that clock counts only while chip select is low. The sync polarity and the active clock edge can each be set. In slave mode, data arriving on a chain input is shifted in behind the result, so several converters can share one data line. A read that is still running when the next conversion completes raises a one-cycle error pulse.

In master mode the frame can start in one of two ways. In read-after-convert timing, the result is sent as soon as the conversion ends, and a two-bit select divides the serial clock down. In read-during-convert timing, the result of the previous conversion is sent when the next conversion starts, and the clock always runs at the base rate. When chip select is high, the data, sync and clock outputs rest at their idle levels and the output enable is low.

Top module: `ser_result_port`

## Requirements
- R1: A load places the 16-bit word in the shift register, and the bits leave most significant bit first, one per active serial edge.
- R2: slave_sel_i low selects master mode and high selects slave mode. In slave mode, external clock edges shift nothing while cs_ni is high.
- R3: In master mode, sync_o is at its active level from the load until the sixteenth bit has been sent. The active level is high when inv_sync_i is 0 and low when inv_sync_i is 1. In slave mode, sync_o stays at its inactive level.
- R4: The active edge is rising when inv_clk_i is 0 and falling when inv_clk_i is 1. The slave changes its data on the active edge. The master changes its data on the inactive edge. An idle sclk_o rests at the level of inv_clk_i.
- R5: In master read-after-convert mode (rd_during_i = 0), each clock phase lasts 2 << div_sel_i system clocks: codes 0, 1, 2 and 3 give 2, 4, 8 and 16 cycles.
- R6: In master read-during-convert mode (rd_during_i = 1), div_sel_i has no effect and each phase lasts 2 system clocks.
- R7: In master read-after-convert mode, eoc_i loads result_i and starts the frame, and conv_start_i has no effect. In read-during-convert mode, eoc_i only stores result_i, and conv_start_i starts a frame that sends the stored word.
- R8: In slave mode, the level of daisy_i sampled at active edge k appears on sdata_o after active edge k+15. The first chain bit is therefore out 16 edges after the read begins.
- R9: In slave mode, eoc_i loads result_i and clears the edge count. If between 1 and 15 active edges have been counted when eoc_i arrives, rd_err_o is high for exactly the next cycle. After 0 or 16 or more edges, rd_err_o stays low.
- R10: While cs_ni is high, sdata_o is 0, sync_o is inactive, sclk_o is at its idle level and out_en_o is 0. With cs_ni low, out_en_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| result_i | input | 16 | Conversion result word |
| eoc_i | input | 1 | End-of-conversion pulse |
| conv_start_i | input | 1 | Conversion-start pulse |
| slave_sel_i | input | 1 | 0 master, 1 slave |
| rd_during_i | input | 1 | 1 read during convert, 0 read after convert |
| inv_sync_i | input | 1 | 1 makes sync active low |
| inv_clk_i | input | 1 | 1 makes the falling edge active |
| div_sel_i | input | 2 | Master clock divide code |
| cs_ni | input | 1 | Chip select, active low |
| ext_sclk_i | input | 1 | External serial clock (slave) |
| daisy_i | input | 1 | Chain data input |
| sdata_o | output | 1 | Serial data |
| sclk_o | output | 1 | Generated serial clock |
| sync_o | output | 1 | Frame sync |
| rd_err_o | output | 1 | Incomplete-read error pulse |
| out_en_o | output | 1 | Output drive enable |

## Verification
Master frames are captured with several words, including 8001 and 7FFE, under every divide code and every mix of clock and sync polarity. This shows whether bit order, phase length and polarity each respond to their own select. The read-during-convert run changes result_i after storing a word, which separates sending the stored word from sending the live input. Slave reads clock 32 edges with a chain pattern that differs from the result, showing where the result ends and the pass-through begins. An eoc_i is issued after 0, 5 and 16 edges to test the error rule at its boundaries, and edges sent while cs_ni is high check that the gating holds the data.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;
  typedef enum logic {MODE_MASTER = 1'b0, MODE_SLAVE = 1'b1} port_mode_e;

  function automatic int unsigned half_cycles(int unsigned base, int unsigned div_log);
    return base << div_log;
  endfunction
endpackage

// File: rtl/ser_edge_sync.sv
module ser_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  input  logic inv_i,
  output logic act_edge_o
);
  logic [STAGES-1:0] pipe_q;
  logic lvl, lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], async_i};
  end

  assign lvl = pipe_q[STAGES-1] ^ inv_i;

  // reset high so no edge is seen before a real rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b1;
    else         lvl_q <= lvl;
  end

  assign act_edge_o = lvl & ~lvl_q;

  a_r4_edge_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_edge_o |=> !act_edge_o);
endmodule

// File: rtl/ser_mclk_gen.sv
module ser_mclk_gen #(
  parameter int DIV_W     = 2,
  parameter int BASE_HALF = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             fall_o
);
  localparam int MAX_HALF = BASE_HALF << ((1 << DIV_W) - 1);
  localparam int HCNT_W   = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

  logic [HCNT_W-1:0] cnt_q, last_cnt;
  logic raw_q;

  always_comb
    last_cnt = HCNT_W'(ser_port_pkg::half_cycles(BASE_HALF, 32'(div_i)) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      raw_q <= 1'b0;
    end else if (clr_i || !run_i) begin
      cnt_q <= '0;
      raw_q <= 1'b0;
    end else if (cnt_q == last_cnt) begin
      cnt_q <= '0;
      raw_q <= ~raw_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sclk_o = raw_q;
  assign fall_o = run_i && !clr_i && raw_q && (cnt_q == last_cnt);

  a_r5_rise_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $past(run_i));
  a_r5_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i && cnt_q != last_cnt) |=> $stable(sclk_o));
endmodule

// File: rtl/ser_shift_core.sv
module ser_shift_core #(
  parameter int W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [W-1:0]               data_i,
  input  logic                       shift_i,
  input  logic                       shift_in_i,
  output logic                       msb_o,
  output logic [$clog2(W+1)-1:0]     count_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     sr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sr_q  <= data_i;
      cnt_q <= '0;
    end else if (shift_i) begin
      sr_q  <= {sr_q[W-2:0], shift_in_i};
      if (cnt_q != CNT_W'(W)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign msb_o   = sr_q[W-1];
  assign count_o = cnt_q;

  a_r1_load_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (msb_o == $past(data_i[W-1])));
  a_r9_count_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(W));
endmodule

// File: rtl/ser_result_port.sv
module ser_result_port #(
  parameter int RES_W       = 16,
  parameter int DIV_W       = 2,
  parameter int BASE_HALF   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RES_W-1:0] result_i,
  input  logic             eoc_i,
  input  logic             conv_start_i,
  input  logic             slave_sel_i,
  input  logic             rd_during_i,
  input  logic             inv_sync_i,
  input  logic             inv_clk_i,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic             cs_ni,
  input  logic             ext_sclk_i,
  input  logic             daisy_i,
  output logic             sdata_o,
  output logic             sclk_o,
  output logic             sync_o,
  output logic             rd_err_o,
  output logic             out_en_o
);
  import ser_port_pkg::*;
  localparam int CNT_W = $clog2(RES_W + 1);

  port_mode_e       mode;
  logic             is_master;
  logic [RES_W-1:0] hold_q, load_data;
  logic             m_busy_q, m_start, m_fall, m_sclk;
  logic             core_load, core_shift, core_in, core_msb;
  logic [CNT_W-1:0] core_cnt;
  logic             ext_act, rd_err_q, cs_live;
  logic [DIV_W-1:0] div_eff;
  logic [SYNC_STAGES-1:0] cs_pipe_q;

  assign mode      = port_mode_e'(slave_sel_i);
  assign is_master = (mode == MODE_MASTER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_pipe_q <= '1;
    else         cs_pipe_q <= {cs_pipe_q[SYNC_STAGES-2:0], cs_ni};
  end
  assign cs_live = ~cs_pipe_q[SYNC_STAGES-1];

  ser_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .async_i    (ext_sclk_i),
    .inv_i      (inv_clk_i),
    .act_edge_o (ext_act)
  );

  always_comb begin
    m_start    = is_master && (rd_during_i ? conv_start_i : eoc_i);
    core_load  = is_master ? m_start : eoc_i;
    load_data  = (is_master && rd_during_i) ? hold_q : result_i;
    core_shift = is_master ? m_fall : (ext_act && cs_live);
    core_in    = is_master ? 1'b0 : daisy_i;
    div_eff    = rd_during_i ? '0 : div_sel_i;
  end

  ser_mclk_gen #(.DIV_W(DIV_W), .BASE_HALF(BASE_HALF)) u_mclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (m_start),
    .run_i  (m_busy_q),
    .div_i  (div_eff),
    .sclk_o (m_sclk),
    .fall_o (m_fall)
  );

  ser_shift_core #(.W(RES_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (core_load),
    .data_i     (load_data),
    .shift_i    (core_shift),
    .shift_in_i (core_in),
    .msb_o      (core_msb),
    .count_o    (core_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= '0;
      m_busy_q <= 1'b0;
      rd_err_q <= 1'b0;
    end else begin
      if (eoc_i) hold_q <= result_i;
      if (!is_master)                                     m_busy_q <= 1'b0;
      else if (m_start)                                   m_busy_q <= 1'b1;
      else if (m_fall && core_cnt == CNT_W'(RES_W - 1))   m_busy_q <= 1'b0;
      // a partial slave read overrun by a new result
      rd_err_q <= !is_master && eoc_i && core_cnt != '0 && core_cnt != CNT_W'(RES_W);
    end
  end

  assign out_en_o = ~cs_ni;
  assign sdata_o  = cs_ni ? 1'b0 : core_msb;
  assign sclk_o   = (cs_ni || !is_master) ? inv_clk_i : (m_sclk ^ inv_clk_i);
  assign sync_o   = (cs_ni || !is_master) ? inv_sync_i : (m_busy_q ^ inv_sync_i);
  assign rd_err_o = rd_err_q;

  a_r9_err_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |=> !rd_err_o);
  a_r9_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> $past(slave_sel_i && eoc_i));
  a_r3_sync_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_master && !cs_ni && m_fall) |-> (sync_o != inv_sync_i));
  a_r4_master_idle_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_master && !m_busy_q) |=> (sclk_o == inv_clk_i) || $past(m_start) || !is_master);
endmodule

// File: tb/sim_ser_result_port.sv
module sim_ser_result_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] result = '0;
  logic eoc = 0, cstart = 0, slave = 0, rdc = 0, inv_s = 0, inv_c = 0;
  logic [1:0] div = '0;
  logic cs_n = 0, ext = 0, daisy = 0;
  logic sdata, sclk, sync, rd_err, oen;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ser_result_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .result_i(result), .eoc_i(eoc), .conv_start_i(cstart),
    .slave_sel_i(slave), .rd_during_i(rdc), .inv_sync_i(inv_s), .inv_clk_i(inv_c),
    .div_sel_i(div), .cs_ni(cs_n), .ext_sclk_i(ext), .daisy_i(daisy),
    .sdata_o(sdata), .sclk_o(sclk), .sync_o(sync), .rd_err_o(rd_err), .out_en_o(oen));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_eoc(input logic [15:0] w);
    @(negedge clk); result = w; eoc = 1;
    @(negedge clk); eoc = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); cstart = 1;
    @(negedge clk); cstart = 0;
  endtask

  // capture one master frame at the active edges
  task automatic mcap(output logic [15:0] w, output int hp, output int bad_sync);
    logic prev;
    int n, t_act;
    prev = sclk; n = 0; t_act = 0; hp = 0; bad_sync = 0; w = '0;
    for (int c = 0; c < 2000 && n < 16; c++) begin
      @(negedge clk);
      if (sclk !== prev) begin
        if (sclk === ~inv_c) begin
          w = {w[14:0], sdata}; n++; t_act = c;
          if (sync !== ~inv_s) bad_sync++;
        end else if (n == 1 && hp == 0) hp = c - t_act;
      end
      prev = sclk;
    end
  endtask

  task automatic slave_edge(input logic d);
    @(negedge clk); daisy = d; ext = ~inv_c;
    wait_n(4); ext = inv_c;
    wait_n(4);
  endtask

  task automatic slave_setup(input logic ic);
    @(negedge clk); cs_n = 1; slave = 1; rdc = 0;
    wait_n(4); inv_c = ic; ext = ic;
    wait_n(6); cs_n = 0;
    wait_n(6);
  endtask

  task automatic t_reset();
    wait_n(3);
    chk("R10 reset sdata", sdata, 0);
    chk("R3 reset sync", sync, 0);
    chk("R4 reset sclk", sclk, 0);
    chk("R9 reset rd_err", rd_err, 0);
    chk("R10 reset oen", oen, 1);
  endtask

  task automatic t_master_rac(input logic [1:0] d, input logic ic, input logic is, input logic [15:0] w);
    logic [15:0] got; int hp, bad;
    @(negedge clk); slave = 0; rdc = 0; cs_n = 0; div = d; inv_c = ic; inv_s = is;
    wait_n(4);
    chk("R4 master idle clk", sclk, ic);
    chk("R3 idle sync", sync, is);
    pulse_eoc(w);
    mcap(got, hp, bad);
    chk("R1 R7 master word", got, w);
    chk("R5 half period", hp, 2 << d);
    chk("R3 sync active", bad, 0);
    wait_n(40);
    chk("R3 sync end", sync, is);
    chk("R4 clk idle end", sclk, ic);
  endtask

  task automatic t_master_rdc();
    logic [15:0] got; int hp, bad;
    @(negedge clk); slave = 0; rdc = 1; div = 2'd3; inv_c = 0; inv_s = 0;
    pulse_eoc(16'h1234);
    @(negedge clk); result = 16'hFFFF;
    wait_n(10);
    chk("R7 eoc no frame in rdc", sync, 0);
    pulse_start();
    mcap(got, hp, bad);
    chk("R7 stored word", got, 16'h1234);
    chk("R6 div ignored", hp, 2);
    chk("R3 rdc sync", bad, 0);
    wait_n(20);
    pulse_eoc(16'h4321);
    @(negedge clk); result = 16'h0000;
    pulse_start();
    mcap(got, hp, bad);
    chk("R7 second stored word", got, 16'h4321);
    wait_n(20);
    @(negedge clk); rdc = 0; div = 0;
    @(negedge clk); cstart = 1;
    @(negedge clk); cstart = 0;
    wait_n(4);
    chk("R7 start ignored rac", sync, 0);
  endtask

  task automatic t_master_cs_high();
    int bad;
    bad = 0;
    @(negedge clk); slave = 0; rdc = 0; div = 0; inv_c = 0; inv_s = 1; cs_n = 1;
    pulse_eoc(16'hFFFF);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (sdata !== 0 || sclk !== 0 || sync !== 1 || oen !== 0) bad++;
    end
    chk("R10 master outputs idle cs high", bad, 0);
    @(negedge clk); cs_n = 0;
    wait_n(4);
  endtask

  task automatic t_slave_read(input logic ic, input logic [15:0] w, input logic [15:0] dv);
    logic exp;
    slave_setup(ic);
    pulse_eoc(w);
    chk("R3 slave sync inactive", sync, inv_s);
    chk("R4 slave clk idle", sclk, ic);
    for (int j = 1; j <= 32; j++) begin
      exp = (j <= 16) ? w[16-j] : dv[32-j];
      chk((j <= 16) ? "R1 R4 slave bit" : "R8 daisy bit", sdata, exp);
      slave_edge((j <= 16) ? dv[16-j] : 1'b0);
    end
    pulse_eoc(16'h0F0F);
    chk("R9 no error after full read", rd_err, 0);
  endtask

  task automatic t_rd_err();
    slave_setup(0);
    pulse_eoc(16'hAAAA);
    pulse_eoc(16'hAAAA);
    chk("R9 no error without read", rd_err, 0);
    for (int i = 0; i < 5; i++) slave_edge(0);
    pulse_eoc(16'h5555);
    chk("R9 error pulse", rd_err, 1);
    @(negedge clk);
    chk("R9 error one cycle", rd_err, 0);
    chk("R9 new word msb", sdata, 0);
    slave_edge(0);
    chk("R9 new word bit14", sdata, 1);
  endtask

  task automatic t_cs_gate();
    slave_setup(0);
    pulse_eoc(16'hC001);
    @(negedge clk); cs_n = 1;
    wait_n(4);
    chk("R10 sdata idle", sdata, 0);
    chk("R10 sync idle", sync, inv_s);
    chk("R10 oen low", oen, 0);
    for (int i = 0; i < 5; i++) slave_edge(0);
    @(negedge clk); cs_n = 0;
    wait_n(4);
    chk("R2 edges gated msb", sdata, 1);
    slave_edge(0);
    chk("R2 bit14", sdata, 1);
    slave_edge(0);
    chk("R2 bit13", sdata, 0);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1;
    t_reset();
    t_master_rac(2'd0, 0, 0, 16'hA5C3);
    t_master_rac(2'd1, 1, 0, 16'h8001);
    t_master_rac(2'd2, 0, 1, 16'h7FFE);
    t_master_rac(2'd3, 1, 1, 16'h3C96);
    t_master_rdc();
    t_master_cs_high();
    inv_s = 0;
    t_slave_read(0, 16'hB2E4, 16'h9C35);
    t_slave_read(1, 16'h4D1B, 16'h63CA);
    t_rd_err();
    t_cs_gate();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule